// File: doc/BRIEF.md
# Serial GPIO Burst Controller

This block drives a serial GPIO chain. The chain has up to 32 ports, and each port carries 1 to 4 bits. A small synchronous register port holds the configuration:

- the number of bits per port;
- the repeat and one-shot controls;
- a clock divider;
- a mask of enabled ports;
- one output configuration word per port.

The block divides the system clock into a serial clock. In each burst it shifts out one bit slot for every bit of every enabled port. Slots go in ascending port order, and in ascending bit order within a port. In the same slot it samples the serial input into one input word per bit index. The bits of an input word are indexed by port. After the last slot a load strobe tells the external shift registers to latch.

Bursts run in one of two ways:

- **One-shot:** a single burst starts when the one-shot bit is set. The hardware clears that bit when the burst ends, but only while auto-repeat is off.
- **Auto-repeat:** bursts follow one another, separated by a gap of a fixed number of serial-clock periods.

Top module: `sgpio_burst_ctrl`

## Requirements
- R1: After reset:
  - `sclk`, `sdo` and `ldStrobe` are low.
  - Every register reads zero.
  - No burst starts until the repeat bit or the one-shot bit is set.
- R2: The control word is at address 0x00. Its field [1:0] holds the bits per port minus one, so 0 to 3 select 1 to 4 bits. A burst has exactly (field+1) serial-clock rising edges for each enabled port.
- R3: Each half period of `sclk` lasts max(2, D) system clocks. D is the 12-bit divider at control bits [27:16], so the values 0 and 1 behave as 2.
- R4: Bits leave in ascending port order, and in ascending bit order within a port. The configuration word of port p is at address 0x20+p. Bit b of the port is driven from bit 3b of that word; the other two bits of each 3-bit field are stored and read back but do not affect `sdo`. `sdo` changes only together with a falling edge of `sclk`, or at the start or end of a burst.
- R5: The enable mask is at address 0x01, bit p for port p. A port whose mask bit is 0 gets no bit slot, and its bits in the input words are left unchanged.
- R6: On each rising edge of `sclk`, `sdi` is stored in bit p of the input word at address 0x08+b, where p and b are the current port and bit. The input words are read-only.
- R7: After the last slot, `ldStrobe` is high for exactly one serial-clock period (2·max(2,D) system clocks). `sclk` stays low while it is high.
- R8: Setting the one-shot bit (control bit 5) starts one burst from idle. If auto-repeat is off, the hardware clears the bit in the cycle the load pulse ends, and the block then idles.
- R9: While auto-repeat (control bit 4) is set, each load pulse is followed by 2·GAP_PERIODS idle half periods, after which a new burst starts. The one-shot bit is never cleared by hardware in this mode.
- R10: A burst with an all-zero enable mask consists of the load pulse alone.
- R11: The bits-per-port field and the enable mask are captured when a burst starts. Writing them during a burst changes only the following bursts.
- R12: A register write to the control word takes priority over the hardware clear of the one-shot bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 6 | Register address, also selects the read data |
| regWrEn | input | 1 | Write strobe, takes effect at the next rising clock edge |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from `regAddr` |
| sdi | input | 1 | Serial input from the chain |
| sclk | output | 1 | Divided serial clock |
| sdo | output | 1 | Serial output data |
| ldStrobe | output | 1 | Load/latch pulse after each burst |

## Verification
The assertions assume that the divider and the repeat bit are not rewritten in the middle of a serial half period. They also assume that `sdi` and the register port are synchronous to `clk`. The bench meets both assumptions: it changes inputs only just after a rising edge, and it rewrites the divider only while the chain is idle. The mid-burst writes it does make touch only the enable mask, which exercises the capture of the mask and width at burst start. `sdi` is fed from a pseudo-random sequence so that the captured input words differ from one burst to the next.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;
  // Default geometry of the chain.
  localparam int SG_NUM_PORTS = 32;
  localparam int SG_MAX_BITS  = 4;
  localparam int SG_PORT_W    = $clog2(SG_NUM_PORTS);
  localparam int SG_BIT_W     = $clog2(SG_MAX_BITS);
  localparam int SG_SRC_W     = 3;

  // Register map.
  localparam int SG_ADDR_CTRL    = 0;
  localparam int SG_ADDR_MASK    = 1;
  localparam int SG_ADDR_IN_BASE = 8;
  localparam int SG_ADDR_CFG_BASE = 32;

  // Control word field positions.
  localparam int CTL_WIDTH_LSB = 0;
  localparam int CTL_AUTO      = 4;
  localparam int CTL_SHOT      = 5;
  localparam int CTL_DIV_LSB   = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LATCH = 2'd2,
    ST_GAP   = 2'd3
  } burstState_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic                active;    // a bit slot is being driven
    logic                sample;    // capture sdi in this cycle
    logic                clearShot; // hardware clear of the one-shot bit
    logic [SG_PORT_W-1:0] portIdx;
    logic [SG_BIT_W-1:0]  bitIdx;
  } dpStrobe_t;
endpackage

// File: rtl/sgpio_datapath.sv
module sgpio_datapath
  import sgpio_pkg::*;
#(
  parameter int NUM_PORTS = SG_NUM_PORTS,
  parameter int MAX_BITS  = SG_MAX_BITS,
  parameter int DIV_W     = 12,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              sdi,
  input  dpStrobe_t         strobes,
  output logic [SG_BIT_W-1:0] cfgWidth,
  output logic              cfgAuto,
  output logic              cfgShot,
  output logic [DIV_W-1:0]  cfgDiv,
  output logic [NUM_PORTS-1:0] cfgMask,
  output logic              sdo
);
  localparam int CFG_W = SG_SRC_W * MAX_BITS;

  logic [CFG_W-1:0]     portCfg [NUM_PORTS];
  logic [NUM_PORTS-1:0] inWord  [MAX_BITS];
  logic [NUM_PORTS-1:0] cfgHit;
  logic                 ctrlHit;
  logic                 maskHit;
  logic [CFG_W-1:0]     selCfg;

  assign ctrlHit = regWrEn && (regAddr == ADDR_W'(SG_ADDR_CTRL));
  assign maskHit = regWrEn && (regAddr == ADDR_W'(SG_ADDR_MASK));

  // One address decoder per port configuration word.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_cfgDec
    assign cfgHit[p] = regWrEn && (regAddr == ADDR_W'(SG_ADDR_CFG_BASE + p));
  end

  // Control word. A write beats the hardware clear of the one-shot bit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgWidth <= '0;
      cfgAuto  <= 1'b0;
      cfgShot  <= 1'b0;
      cfgDiv   <= '0;
    end else if (ctrlHit) begin
      cfgWidth <= regWrData[CTL_WIDTH_LSB +: SG_BIT_W];
      cfgAuto  <= regWrData[CTL_AUTO];
      cfgShot  <= regWrData[CTL_SHOT];
      cfgDiv   <= regWrData[CTL_DIV_LSB +: DIV_W];
    end else if (strobes.clearShot) begin
      cfgShot  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgMask <= '0;
    else if (maskHit) cfgMask <= regWrData[NUM_PORTS-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PORTS; p++) portCfg[p] <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++)
        if (cfgHit[p]) portCfg[p] <= regWrData[CFG_W-1:0];
    end
  end

  // Input capture, one word per bit index, indexed by port.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < MAX_BITS; b++) inWord[b] <= '0;
    end else if (strobes.sample) begin
      for (int b = 0; b < MAX_BITS; b++)
        if (strobes.bitIdx == SG_BIT_W'(b)) inWord[b][strobes.portIdx] <= sdi;
    end
  end

  // Output bit: the lowest bit of the selected 3-bit source field.
  assign selCfg = portCfg[strobes.portIdx];
  always_comb begin
    sdo = 1'b0;
    for (int b = 0; b < MAX_BITS; b++)
      if (strobes.active && strobes.bitIdx == SG_BIT_W'(b)) sdo = selCfg[SG_SRC_W*b];
  end

  // Read mux.
  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(SG_ADDR_CTRL)) begin
      regRdData[CTL_WIDTH_LSB +: SG_BIT_W] = cfgWidth;
      regRdData[CTL_AUTO]                  = cfgAuto;
      regRdData[CTL_SHOT]                  = cfgShot;
      regRdData[CTL_DIV_LSB +: DIV_W]      = cfgDiv;
    end
    if (regAddr == ADDR_W'(SG_ADDR_MASK)) regRdData[NUM_PORTS-1:0] = cfgMask;
    for (int b = 0; b < MAX_BITS; b++)
      if (regAddr == ADDR_W'(SG_ADDR_IN_BASE + b)) regRdData[NUM_PORTS-1:0] = inWord[b];
    for (int p = 0; p < NUM_PORTS; p++)
      if (regAddr == ADDR_W'(SG_ADDR_CFG_BASE + p)) regRdData[CFG_W-1:0] = portCfg[p];
  end

  // The one-shot bit survives while repeat is on unless software rewrites it.
  AST_SHOT_HELD_IN_REPEAT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cfgAuto) && $past(cfgShot) && !$past(regWrEn)) |-> cfgShot); // R9

  // A hardware clear is only requested while repeat is off.
  AST_CLEAR_ONLY_ONESHOT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearShot |-> !cfgAuto); // R8
endmodule

// File: rtl/sgpio_control.sv
module sgpio_control
  import sgpio_pkg::*;
#(
  parameter int NUM_PORTS   = SG_NUM_PORTS,
  parameter int DIV_W       = 12,
  parameter int GAP_PERIODS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SG_BIT_W-1:0]  cfgWidth,
  input  logic                 cfgAuto,
  input  logic                 cfgShot,
  input  logic [DIV_W-1:0]     cfgDiv,
  input  logic [NUM_PORTS-1:0] cfgMask,
  output dpStrobe_t            strobes,
  output logic                 sclk,
  output logic                 ldStrobe
);
  localparam int PORT_W     = $clog2(NUM_PORTS);
  localparam int GAP_HALVES = 2 * GAP_PERIODS;
  localparam int GAP_CNT_W  = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;

  burstState_t          state;
  logic [DIV_W-1:0]     prescCnt;
  logic [DIV_W-1:0]     divEff;
  logic                 tick;
  logic                 sclkQ;
  logic [PORT_W-1:0]    curPort;
  logic [SG_BIT_W-1:0]  curBit;
  logic [SG_BIT_W-1:0]  burstWidth;
  logic [NUM_PORTS-1:0] burstMask;
  logic                 latchHalf;
  logic [GAP_CNT_W-1:0] gapCnt;
  logic [PORT_W-1:0]    firstPort;
  logic [PORT_W-1:0]    nextPort;
  logic                 nextValid;
  logic                 startReq;
  logic                 shotDone;

  // Divider values 0 and 1 are treated as 2.
  assign divEff   = (cfgDiv < DIV_W'(2)) ? DIV_W'(2) : cfgDiv;
  assign tick     = (state != ST_IDLE) && (prescCnt >= divEff - 1'b1);
  assign startReq = cfgAuto || cfgShot;
  assign shotDone = (state == ST_LATCH) && tick && latchHalf && !cfgAuto;

  // Lowest enabled port of the live mask, and the next enabled port above
  // the current one in the mask captured for this burst.
  always_comb begin
    firstPort = '0;
    for (int p = NUM_PORTS - 1; p >= 0; p--)
      if (cfgMask[p]) firstPort = PORT_W'(p);
  end

  always_comb begin
    nextPort  = '0;
    nextValid = 1'b0;
    for (int p = NUM_PORTS - 1; p >= 0; p--)
      if (burstMask[p] && (p > int'(curPort))) begin
        nextPort  = PORT_W'(p);
        nextValid = 1'b1;
      end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prescCnt <= '0;
    else if (state == ST_IDLE || tick) prescCnt <= '0;
    else prescCnt <= prescCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      sclkQ      <= 1'b0;
      curPort    <= '0;
      curBit     <= '0;
      burstWidth <= '0;
      burstMask  <= '0;
      latchHalf  <= 1'b0;
      gapCnt     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            burstWidth <= cfgWidth;
            burstMask  <= cfgMask;
            curPort    <= firstPort;
            curBit     <= '0;
            sclkQ      <= 1'b0;
            latchHalf  <= 1'b0;
            state      <= (cfgMask != '0) ? ST_SHIFT : ST_LATCH;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sclkQ) begin
              sclkQ <= 1'b1;
            end else begin
              sclkQ <= 1'b0;
              if (curBit != burstWidth) begin
                curBit <= curBit + 1'b1;
              end else if (nextValid) begin
                curPort <= nextPort;
                curBit  <= '0;
              end else begin
                latchHalf <= 1'b0;
                state     <= ST_LATCH;
              end
            end
          end
        end
        ST_LATCH: begin
          if (tick) begin
            if (!latchHalf) begin
              latchHalf <= 1'b1;
            end else if (cfgAuto) begin
              gapCnt <= '0;
              state  <= ST_GAP;
            end else begin
              state  <= ST_IDLE;
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gapCnt == GAP_CNT_W'(GAP_HALVES - 1)) state <= ST_IDLE;
            else gapCnt <= gapCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.active    = (state == ST_SHIFT);
    strobes.sample    = (state == ST_SHIFT) && tick && !sclkQ;
    strobes.clearShot = shotDone;
    strobes.portIdx   = curPort;
    strobes.bitIdx    = curBit;
  end

  assign sclk     = sclkQ;
  assign ldStrobe = (state == ST_LATCH);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick); // R3

  AST_LOAD_WITH_SCLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LATCH) |-> !sclkQ); // R7

  AST_SLOT_HELD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclkQ && $past(sclkQ)) |-> ($stable(curPort) && $stable(curBit))); // R4

  AST_SAMPLE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sample |=> sclkQ); // R6

  AST_LOAD_MIN_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ldStrobe) |=> ldStrobe); // R7
endmodule

// File: rtl/sgpio_burst_ctrl.sv
module sgpio_burst_ctrl
  import sgpio_pkg::*;
#(
  parameter int NUM_PORTS   = SG_NUM_PORTS,
  parameter int MAX_BITS    = SG_MAX_BITS,
  parameter int DIV_W       = 12,
  parameter int GAP_PERIODS = 2,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              sdi,
  output logic              sclk,
  output logic              sdo,
  output logic              ldStrobe
);
  dpStrobe_t            strobes;
  logic [SG_BIT_W-1:0]  cfgWidth;
  logic                 cfgAuto;
  logic                 cfgShot;
  logic [DIV_W-1:0]     cfgDiv;
  logic [NUM_PORTS-1:0] cfgMask;

  sgpio_datapath #(
    .NUM_PORTS(NUM_PORTS), .MAX_BITS(MAX_BITS), .DIV_W(DIV_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .sdi(sdi),
    .strobes(strobes), .cfgWidth(cfgWidth), .cfgAuto(cfgAuto),
    .cfgShot(cfgShot), .cfgDiv(cfgDiv), .cfgMask(cfgMask), .sdo(sdo)
  );

  sgpio_control #(
    .NUM_PORTS(NUM_PORTS), .DIV_W(DIV_W), .GAP_PERIODS(GAP_PERIODS)
  ) u_control (
    .clk(clk), .rstN(rstN), .cfgWidth(cfgWidth), .cfgAuto(cfgAuto),
    .cfgShot(cfgShot), .cfgDiv(cfgDiv), .cfgMask(cfgMask),
    .strobes(strobes), .sclk(sclk), .ldStrobe(ldStrobe)
  );
endmodule

// File: tb/sgpio_burst_ctrl_tb.sv
module sgpio_burst_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TB_GAP     = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        sdi = 1'b0;
  logic        sclk, sdo, ldStrobe;

  int vecCnt = 0;
  int failCnt = 0;
  int cycles = 0;
  bit running = 0;

  sgpio_burst_ctrl #(.GAP_PERIODS(TB_GAP)) u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .sdi(sdi),
    .sclk(sclk), .sdo(sdo), .ldStrobe(ldStrobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference ----------------
  logic [31:0] mCtrl = 0, mMask = 0;
  logic [11:0] mCfg [32];
  logic [31:0] mIn [4];
  int  slots[$];
  int  mPh = 0, mCnt = 0, mHalfs = 0, mSclk = 0;
  int  dEff;
  bit  ar, ss, clr;

  task automatic mReset();
    mCtrl = 0; mMask = 0; mPh = 0; mCnt = 0; mHalfs = 0; mSclk = 0;
    slots.delete();
    for (int p = 0; p < 32; p++) mCfg[p] = 0;
    for (int b = 0; b < 4; b++) mIn[b] = 0;
  endtask

  initial mReset();

  always @(posedge clk) begin
    if (!rstN) mReset();
    else begin
      dEff = (mCtrl[27:16] < 2) ? 2 : int'(mCtrl[27:16]);
      ar = mCtrl[4]; ss = mCtrl[5]; clr = 0;
      if (mPh == 0) begin
        if (ar || ss) begin
          slots.delete();
          for (int p = 0; p < 32; p++)
            if (mMask[p]) for (int b = 0; b <= int'(mCtrl[1:0]); b++) slots.push_back(p*4 + b);
          mCnt = 0; mHalfs = 0; mSclk = 0;
          mPh = (slots.size() > 0) ? 1 : 2;
        end
      end else if (mCnt < dEff - 1) mCnt++;
      else begin
        mCnt = 0;
        if (mPh == 1) begin
          if (mSclk == 0) begin
            mSclk = 1;
            mIn[slots[0] % 4][slots[0] / 4] = sdi;
          end else begin
            mSclk = 0;
            void'(slots.pop_front());
            if (slots.size() == 0) begin mPh = 2; mHalfs = 0; end
          end
        end else if (mPh == 2) begin
          mHalfs++;
          if (mHalfs == 2) begin
            mHalfs = 0;
            if (ar) mPh = 3; else begin mPh = 0; clr = 1; end
          end
        end else begin
          mHalfs++;
          if (mHalfs == 2*TB_GAP) begin mPh = 0; mHalfs = 0; end
        end
      end
      if (clr) mCtrl[5] = 0;
      if (regWrEn) begin
        if (regAddr == 0) mCtrl = regWrData & 32'h0FFF_0033;
        else if (regAddr == 1) mMask = regWrData;
        else if (regAddr >= 32) mCfg[regAddr - 32] = regWrData[11:0];
      end
    end
  end

  function automatic logic [31:0] mRead(logic [5:0] a);
    if (a == 0) return mCtrl;
    if (a == 1) return mMask;
    if (a >= 8 && a < 12) return mIn[a - 8];
    if (a >= 32) return {20'd0, mCfg[a - 32]};
    return 0;
  endfunction

  function automatic logic mSdo();
    if (mPh != 1) return 0;
    return mCfg[slots[0] / 4][3 * (slots[0] % 4)];
  endfunction

  task automatic check(string tag, string what, longint got, longint exp);
    vecCnt++;
    if (got != exp) begin
      failCnt++;
      $display("FAIL %s %s: got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  // ---------------- per-cycle compare and monitors ----------------
  int riseCnt = 0, hiRun = 0, hiLen = 0, ldRun = 0, ldLen = 0, ldFalls = 0;
  logic prevSclk = 0, prevLd = 0;

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failCnt++;
      $display("FAIL watchdog: got %0d exp below 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
    if (running) begin
      check("R3", "sclk", sclk, mSclk);
      check("R4", "sdo", sdo, mSdo());
      check("R7", "ldStrobe", ldStrobe, (mPh == 2));
      check("R6", "regRdData", regRdData, mRead(regAddr));
      if (sclk && !prevSclk) riseCnt++;
      if (sclk) hiRun++;
      else if (prevSclk) begin hiLen = hiRun; hiRun = 0; end
      if (ldStrobe) ldRun++;
      else if (prevLd) begin ldLen = ldRun; ldRun = 0; ldFalls++; end
      prevSclk = sclk; prevLd = ldStrobe;
    end
  end

  // ---------------- stimulus ----------------
  initial begin : sdiGen
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sdi = lfsr[0];
    end
  end

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(posedge clk); #1;
    regAddr = a; regWrData = d; regWrEn = 1;
    @(posedge clk); #1;
    regWrEn = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    regAddr = a;
    @(negedge clk); #1;
    d = regRdData;
  endtask

  task automatic waitLoads(int n);
    int target;
    target = ldFalls + n;
    while (ldFalls < target) @(negedge clk);
  endtask

  task automatic clearMon();
    @(posedge clk); #1;
    riseCnt = 0;
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    running = 1;

    // R1: reset state
    check("R1", "sclk", sclk, 0);
    check("R1", "sdo", sdo, 0);
    check("R1", "ldStrobe", ldStrobe, 0);
    rd(0, v);  check("R1", "ctrl", v, 0);
    rd(1, v);  check("R1", "mask", v, 0);
    rd(8, v);  check("R1", "inword0", v, 0);
    rd(33, v); check("R1", "cfg1", v, 0);
    repeat (20) @(posedge clk);
    check("R1", "no load while idle", ldFalls, 0);

    // Configuration words; the upper bits of each field are random (R4).
    for (int p = 0; p < 32; p++) wr(6'(32 + p), ((p * 32'h9E3) ^ 32'h5A5) & 32'hFFF);
    rd(40, v); check("R4", "cfg8 readback", v, ((8 * 32'h9E3) ^ 32'h5A5) & 32'hFFF);

    // Sparse mask, 2 bits per port, divider 3, one-shot (R2 R5 R8 R3 R7)
    wr(1, 32'h8000_0005);
    clearMon();
    wr(0, (32'd3 << 16) | (1 << 5) | 32'd1);
    waitLoads(1);
    check("R2", "rises sparse", riseCnt, 6);
    check("R3", "half period div3", hiLen, 3);
    check("R7", "load length div3", ldLen, 6);
    rd(0, v); check("R8", "oneshot cleared", v[5], 0);
    rd(8, v); check("R5", "disabled ports untouched", v & 32'h7FFF_FFFA, 0);
    rd(9, v); check("R6", "inword1", v, mIn[1]);

    // All ports, 4 bits, divider 0 acts as 2 (R2 R3 R6)
    wr(1, 32'hFFFF_FFFF);
    clearMon();
    wr(0, (1 << 5) | 32'd3);
    waitLoads(1);
    check("R2", "rises full", riseCnt, 128);
    check("R3", "half period div0", hiLen, 2);
    rd(11, v); check("R6", "inword3", v, mIn[3]);

    // Empty mask: load pulse only (R10)
    wr(1, 32'h0);
    clearMon();
    wr(0, (32'd4 << 16) | (1 << 5));
    waitLoads(1);
    check("R10", "no rises", riseCnt, 0);
    check("R10", "load length div4", ldLen, 8);

    // Auto-repeat with one-shot set (R9)
    wr(1, 32'h3);
    clearMon();
    wr(0, (32'd2 << 16) | (1 << 5) | (1 << 4));
    waitLoads(3);
    check("R9", "rises over 3 bursts", riseCnt, 6);
    rd(0, v); check("R9", "oneshot kept", v[5], 1);
    wr(0, 32'd2 << 16);
    repeat (60) @(posedge clk);

    // Mid-burst mask change (R11)
    wr(1, 32'hF);
    clearMon();
    wr(0, (32'd2 << 16) | (1 << 5) | 32'd3);
    repeat (20) @(posedge clk);
    wr(1, 32'h1);
    waitLoads(1);
    check("R11", "captured mask", riseCnt, 16);
    clearMon();
    wr(0, (32'd2 << 16) | (1 << 5) | 32'd3);
    waitLoads(1);
    check("R11", "new mask next burst", riseCnt, 4);

    // Write collides with the hardware clear (R12)
    wr(1, 32'h1);
    @(posedge clk); #1;
    regAddr = 0; regWrData = (32'd2 << 16) | (1 << 5); regWrEn = 1;
    @(posedge clk); #1; regWrEn = 0;
    while (!ldStrobe) @(negedge clk);
    repeat (3) @(posedge clk);
    #1 regWrEn = 1;
    @(posedge clk); #1 regWrEn = 0;
    @(negedge clk);
    rd(0, v); check("R12", "write wins over clear", v[5], mCtrl[5]);
    wr(0, 32'd0);
    repeat (80) @(posedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end
endmodule